// File: doc/BRIEF.md
# Interlaced Field Vertical Sync Sequencer

This block walks the lines of an interlaced picture, one field after the other, and tells the rest of the video path what kind of line is on the wire. A separate line timer supplies the clock position inside the current line and a one-clock pulse on the last clock of every line. From these the sequencer keeps its own line index and field flag. It reports for each line whether it is overscan, picture or vertical interval. For picture lines it also gives the row number.

During the vertical interval every line is treated as two half-line slots. The first slot starts at clock 0 and the second at clock `LINE_CLKS/2`. Each slot carries either a short-sync equalizing pulse or a long-sync serration pulse. The block builds the composite sync level for the current clock from the slot kind and the offset into the slot. Outside the vertical interval the horizontal sync from the line timer passes straight through.

The two fields differ in length and in how the pulse kinds fall on the half-line slots. The longer field has an odd number of leading equalizing halves, so two of its lines pair one pulse kind with the other. The shorter field has an even number, so every one of its lines is uniform. This offset of one half line is what interlaces the two fields. With the default parameters the longer field is 263 lines and the shorter is 262, for 525 lines per frame.

Top module: `fieldseq_vsync`

## Requirements
- R1: While `rst_n` is low and after its release, the block is at line 0 of the longer field: `field_odd`=0, `line_kind`=0 (overscan) and `row`=0.
- R2: `line_kind` encodes overscan as 0, picture as 1 and vertical interval as 2; the value 3 never appears. In the longer field (`field_odd`=0), lines run `TOP_LINES_A` overscan, then `ACTIVE_LINES` picture, then `BOTTOM_LINES` overscan, then (`PRE_EQ_A`+`SER_HALVES`+`POST_EQ_A`)/2 vertical lines.
- R3: In the shorter field (`field_odd`=1), lines run `TOP_LINES_B` overscan, then `ACTIVE_LINES` picture, then `BOTTOM_LINES` overscan, then (`PRE_EQ_B`+`SER_HALVES`+`POST_EQ_B`)/2 vertical lines.
- R4: On picture lines `row` counts 0 to `ACTIVE_LINES`-1, one step per line. On all other lines `row` is 0.
- R5: `field_odd` toggles only on the `line_end` pulse of the last vertical line of a field, so the fields alternate. The next line is line 0 of the other field.
- R6: A vertical line has half-slot number 2*v for clocks 0 to `LINE_CLKS/2`-1 and 2*v+1 for the rest of the line, where v is the vertical line index from 0. The offset into the slot is the clock position modulo `LINE_CLKS/2`.
- R7: In an equalizing slot, sync is asserted for offsets 0 to `EQ_SYNC_CLKS`-1 and deasserted for the rest of the slot.
- R8: In a serration slot, sync is asserted for offsets 0 to `SER_SYNC_CLKS`-1 and deasserted for the rest of the slot.
- R9: In the longer field, half-slots 0 to `PRE_EQ_A`-1 are equalizing, the next `SER_HALVES` slots are serration, and the rest are equalizing. By default this gives 7 equalizing, 6 serration and 7 equalizing halves, so vertical lines 3 and 6 are mixed.
- R10: In the shorter field, half-slots 0 to `PRE_EQ_B`-1 are equalizing, the next `SER_HALVES` slots are serration, and the rest are equalizing. By default this gives 6, 6 and 6 halves.
- R11: Outside the vertical interval `sync_out` equals `hsync_in`. Inside it, `hsync_in` has no effect. With `SYNC_ACTIVE_LOW`=0, asserted sync is 1 on both pins; with `SYNC_ACTIVE_LOW`=1, it is 0.
- R12: `line_kind`, `row` and `field_odd` change only on a clock edge where `line_end` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_end | input | 1 | One-clock pulse on the last clock of each line |
| clk_pos | input | POS_W | Clock position inside the current line, 0 to LINE_CLKS-1 |
| hsync_in | input | 1 | Horizontal sync level from the line timer |
| line_kind | output | 2 | 0 overscan, 1 picture, 2 vertical interval |
| row | output | ROW_W | Picture row number, 0 outside picture lines |
| field_odd | output | 1 | 0 in the longer field, 1 in the shorter field |
| sync_out | output | 1 | Composite sync level for the current clock |

## Verification
A wrong line index or field flag shows at the ports as a misplaced change of `line_kind` or `row` within one line of the fault. It also shifts every later boundary, so the sweep over three full frames exposes it at the next region change. A wrong half-slot kind or pulse width shows on `sync_out` in the very clock where the pulse should end. This matters most at the mixed lines of the longer field, where one half of a line differs from the other. A pass-through fault shows as `sync_out` failing to follow `hsync_in`, or following it during the vertical interval. The bench varies `hsync_in` on every clock, so either fault shows within a few clocks.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;

   typedef enum logic [1:0] {
      LK_OVERSCAN = 2'd0,
      LK_ACTIVE   = 2'd1,
      LK_VERTICAL = 2'd2
   } line_kind_t;

   typedef enum logic {
      SLOT_EQUALIZE = 1'b0,
      SLOT_SERRATE  = 1'b1
   } slot_kind_t;

endpackage

// File: rtl/fsq_line_tracker.sv
`timescale 1ns/1ps
module fsq_line_tracker #(
   parameter int FIELD_A = 263,
   parameter int FIELD_B = 262,
   parameter int LINE_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_end,
   output logic [LINE_W-1:0] line_idx,
   output logic              field_odd
);

   localparam logic [LINE_W-1:0] LAST_A = LINE_W'(FIELD_A - 1);
   localparam logic [LINE_W-1:0] LAST_B = LINE_W'(FIELD_B - 1);

   logic at_last;

   always_comb begin
      at_last = field_odd ? (line_idx == LAST_B) : (line_idx == LAST_A);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_idx  <= '0;
         field_odd <= 1'b0;
      end else if (line_end) begin
         if (at_last) begin
            line_idx  <= '0;
            field_odd <= ~field_odd;
         end else begin
            line_idx  <= line_idx + LINE_W'(1);
         end
      end
   end

endmodule

// File: rtl/fsq_region_map.sv
`timescale 1ns/1ps
module fsq_region_map
   import fsq_pkg::*;
#(
   parameter int TOP_LINES_A  = 14,
   parameter int TOP_LINES_B  = 14,
   parameter int ACTIVE_LINES = 224,
   parameter int BOTTOM_LINES = 15,
   parameter int LINE_W       = 9,
   parameter int ROW_W        = 8,
   parameter int VL_W         = 4
) (
   input  logic [LINE_W-1:0] line_idx,
   input  logic              field_odd,
   output line_kind_t        kind,
   output logic [ROW_W-1:0]  row,
   output logic [VL_W-1:0]   vline
);

   int top_n;
   int idx_i;
   int row_i;
   int vl_i;

   always_comb begin
      top_n = field_odd ? TOP_LINES_B : TOP_LINES_A;
      idx_i = int'(line_idx);
      row_i = 0;
      vl_i  = idx_i - (top_n + ACTIVE_LINES + BOTTOM_LINES);
      if (idx_i < top_n) begin
         kind = LK_OVERSCAN;
      end else if (idx_i < top_n + ACTIVE_LINES) begin
         kind  = LK_ACTIVE;
         row_i = idx_i - top_n;
      end else if (idx_i < top_n + ACTIVE_LINES + BOTTOM_LINES) begin
         kind = LK_OVERSCAN;
      end else begin
         kind = LK_VERTICAL;
      end
      row   = row_i[ROW_W-1:0];
      vline = vl_i[VL_W-1:0];
   end

endmodule

// File: rtl/fsq_vsync_gen.sv
`timescale 1ns/1ps
module fsq_vsync_gen
   import fsq_pkg::*;
#(
   parameter int HALF_CLKS     = 455,
   parameter int POS_W         = 10,
   parameter int VL_W          = 4,
   parameter int EQ_SYNC_CLKS  = 33,
   parameter int SER_SYNC_CLKS = 391,
   parameter int PRE_EQ_A      = 7,
   parameter int PRE_EQ_B      = 6,
   parameter int SER_HALVES    = 6
) (
   input  logic [POS_W-1:0] clk_pos,
   input  logic [VL_W-1:0]  vline,
   input  logic             field_odd,
   output logic             vsync_raw
);

   int         pos_i;
   int         offset;
   int         half_no;
   int         pre_n;
   slot_kind_t slot;

   always_comb begin
      pos_i   = int'(clk_pos);
      pre_n   = field_odd ? PRE_EQ_B : PRE_EQ_A;
      half_no = 2 * int'(vline);
      offset  = pos_i;
      if (pos_i >= HALF_CLKS) begin
         half_no = half_no + 1;
         offset  = pos_i - HALF_CLKS;
      end
      if (half_no >= pre_n && half_no < pre_n + SER_HALVES) begin
         slot = SLOT_SERRATE;
      end else begin
         slot = SLOT_EQUALIZE;
      end
      if (slot == SLOT_SERRATE) begin
         vsync_raw = (offset < SER_SYNC_CLKS);
      end else begin
         vsync_raw = (offset < EQ_SYNC_CLKS);
      end
   end

endmodule

// File: rtl/fieldseq_vsync.sv
`timescale 1ns/1ps
module fieldseq_vsync
   import fsq_pkg::*;
#(
   parameter int LINE_CLKS       = 910,
   parameter int EQ_SYNC_CLKS    = 33,
   parameter int SER_SYNC_CLKS   = 391,
   parameter int TOP_LINES_A     = 14,
   parameter int TOP_LINES_B     = 14,
   parameter int ACTIVE_LINES    = 224,
   parameter int BOTTOM_LINES    = 15,
   parameter int PRE_EQ_A        = 7,
   parameter int PRE_EQ_B        = 6,
   parameter int SER_HALVES      = 6,
   parameter int POST_EQ_A       = 7,
   parameter int POST_EQ_B       = 6,
   parameter bit SYNC_ACTIVE_LOW = 1'b0,
   parameter int POS_W           = $clog2(LINE_CLKS),
   parameter int ROW_W           = $clog2(ACTIVE_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_end,
   input  logic [POS_W-1:0] clk_pos,
   input  logic             hsync_in,
   output logic [1:0]       line_kind,
   output logic [ROW_W-1:0] row,
   output logic             field_odd,
   output logic             sync_out
);

   localparam int HALF_CLKS = LINE_CLKS / 2;
   localparam int VLINES_A  = (PRE_EQ_A + SER_HALVES + POST_EQ_A) / 2;
   localparam int VLINES_B  = (PRE_EQ_B + SER_HALVES + POST_EQ_B) / 2;
   localparam int FIELD_A   = TOP_LINES_A + ACTIVE_LINES + BOTTOM_LINES + VLINES_A;
   localparam int FIELD_B   = TOP_LINES_B + ACTIVE_LINES + BOTTOM_LINES + VLINES_B;
   localparam int FIELD_MAX = (FIELD_A > FIELD_B) ? FIELD_A : FIELD_B;
   localparam int VL_MAX    = (VLINES_A > VLINES_B) ? VLINES_A : VLINES_B;
   localparam int LINE_W    = $clog2(FIELD_MAX);
   localparam int VL_W      = (VL_MAX > 1) ? $clog2(VL_MAX) : 1;

   // elaboration-time parameter checks
   if (LINE_CLKS % 2 != 0) begin : g_bad_line
      $error("LINE_CLKS must be even");
   end
   if (POS_W < $clog2(LINE_CLKS)) begin : g_bad_pos
      $error("POS_W too narrow for LINE_CLKS");
   end
   if (ACTIVE_LINES < 2 || ROW_W < $clog2(ACTIVE_LINES)) begin : g_bad_row
      $error("ROW_W too narrow or ACTIVE_LINES below 2");
   end
   if (!(EQ_SYNC_CLKS > 0 && EQ_SYNC_CLKS < SER_SYNC_CLKS && SER_SYNC_CLKS < HALF_CLKS)) begin : g_bad_sync
      $error("sync widths must satisfy 0 < EQ < SER < LINE_CLKS/2");
   end
   if ((PRE_EQ_A + SER_HALVES + POST_EQ_A) % 2 != 0 ||
       (PRE_EQ_B + SER_HALVES + POST_EQ_B) % 2 != 0) begin : g_bad_halves
      $error("vertical half-slot totals must be even");
   end

   logic [LINE_W-1:0] line_idx;
   logic [VL_W-1:0]   vline;
   line_kind_t        kind;
   logic              vsync_raw;
   logic              vsync_lvl;

   fsq_line_tracker #(
      .FIELD_A (FIELD_A),
      .FIELD_B (FIELD_B),
      .LINE_W  (LINE_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_end  (line_end),
      .line_idx  (line_idx),
      .field_odd (field_odd)
   );

   fsq_region_map #(
      .TOP_LINES_A  (TOP_LINES_A),
      .TOP_LINES_B  (TOP_LINES_B),
      .ACTIVE_LINES (ACTIVE_LINES),
      .BOTTOM_LINES (BOTTOM_LINES),
      .LINE_W       (LINE_W),
      .ROW_W        (ROW_W),
      .VL_W         (VL_W)
   ) u_map (
      .line_idx  (line_idx),
      .field_odd (field_odd),
      .kind      (kind),
      .row       (row),
      .vline     (vline)
   );

   fsq_vsync_gen #(
      .HALF_CLKS     (HALF_CLKS),
      .POS_W         (POS_W),
      .VL_W          (VL_W),
      .EQ_SYNC_CLKS  (EQ_SYNC_CLKS),
      .SER_SYNC_CLKS (SER_SYNC_CLKS),
      .PRE_EQ_A      (PRE_EQ_A),
      .PRE_EQ_B      (PRE_EQ_B),
      .SER_HALVES    (SER_HALVES)
   ) u_vsync (
      .clk_pos   (clk_pos),
      .vline     (vline),
      .field_odd (field_odd),
      .vsync_raw (vsync_raw)
   );

   // output polarity variant
   if (SYNC_ACTIVE_LOW) begin : g_pol_low
      assign vsync_lvl = ~vsync_raw;
   end else begin : g_pol_high
      assign vsync_lvl = vsync_raw;
   end

   assign line_kind = kind;
   assign sync_out  = (kind == LK_VERTICAL) ? vsync_lvl : hsync_in;

endmodule

// File: rtl/fsq_checker.sv
`timescale 1ns/1ps
module fsq_checker #(
   parameter int HALF_CLKS       = 455,
   parameter int SER_SYNC_CLKS   = 391,
   parameter int ACTIVE_LINES    = 224,
   parameter bit SYNC_ACTIVE_LOW = 1'b0,
   parameter int POS_W           = 10,
   parameter int ROW_W           = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_end,
   input logic [POS_W-1:0] clk_pos,
   input logic             hsync_in,
   input logic [1:0]       line_kind,
   input logic [ROW_W-1:0] row,
   input logic             field_odd,
   input logic             sync_out
);

   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ACTIVE_LINES - 1);
   localparam logic [POS_W-1:0] HALF_P   = POS_W'(HALF_CLKS);
   localparam logic [POS_W-1:0] SER_P    = POS_W'(SER_SYNC_CLKS);
   localparam logic [POS_W-1:0] SER2_P   = POS_W'(HALF_CLKS + SER_SYNC_CLKS);
   localparam logic             ASSERTED = ~SYNC_ACTIVE_LOW;

   assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_kind != 2'd3);

   assert_row_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_kind != 2'd1) |-> (row == '0));

   assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_end && line_kind == 2'd1 && row != ROW_LAST) |=>
         (line_kind == 2'd1 && row == $past(row) + ROW_W'(1)));

   assert_field_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(field_odd) || $fell(field_odd)) |->
         ($past(line_end) && $past(line_kind) == 2'd2));

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !line_end |=> ($stable(line_kind) && $stable(row) && $stable(field_odd)));

   assert_pass_through_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (line_kind != 2'd2) |-> (sync_out == hsync_in));

   assert_slot_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_kind == 2'd2 && (clk_pos == '0 || clk_pos == HALF_P)) |->
         (sync_out == ASSERTED));

   assert_serr_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (line_kind == 2'd2 && (clk_pos == SER_P || clk_pos == SER2_P)) |->
         (sync_out != ASSERTED));

endmodule

bind fieldseq_vsync fsq_checker #(
   .HALF_CLKS       (LINE_CLKS / 2),
   .SER_SYNC_CLKS   (SER_SYNC_CLKS),
   .ACTIVE_LINES    (ACTIVE_LINES),
   .SYNC_ACTIVE_LOW (SYNC_ACTIVE_LOW),
   .POS_W           (POS_W),
   .ROW_W           (ROW_W)
) u_fsq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_end  (line_end),
   .clk_pos   (clk_pos),
   .hsync_in  (hsync_in),
   .line_kind (line_kind),
   .row       (row),
   .field_odd (field_odd),
   .sync_out  (sync_out)
);

// File: tb/fieldseq_vsync_test.sv
`timescale 1ns/1ps
module fieldseq_vsync_test;

   localparam int LC    = 40;
   localparam int HALF  = LC / 2;
   localparam int EQS   = 3;
   localparam int SERS  = 15;
   localparam int TA    = 2;
   localparam int TB    = 1;
   localparam int ACT   = 4;
   localparam int BOT   = 2;
   localparam int PREA  = 7;
   localparam int PREB  = 6;
   localparam int SERH  = 6;
   localparam int POSTA = 7;
   localparam int POSTB = 6;
   localparam int FA    = TA + ACT + BOT + (PREA + SERH + POSTA) / 2;
   localparam int FB    = TB + ACT + BOT + (PREB + SERH + POSTB) / 2;
   localparam int PW    = 6;
   localparam int RW    = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          line_end;
   logic [PW-1:0] clk_pos;
   logic          hsync_in;
   logic [1:0]    line_kind;
   logic [RW-1:0] row;
   logic          field_odd;
   logic          sync_out;

   int vectors     = 0;
   int miscompares = 0;
   bit done        = 1'b0;

   always #4 clk = ~clk;

   fieldseq_vsync #(
      .LINE_CLKS     (LC),
      .EQ_SYNC_CLKS  (EQS),
      .SER_SYNC_CLKS (SERS),
      .TOP_LINES_A   (TA),
      .TOP_LINES_B   (TB),
      .ACTIVE_LINES  (ACT),
      .BOTTOM_LINES  (BOT),
      .PRE_EQ_A      (PREA),
      .PRE_EQ_B      (PREB),
      .SER_HALVES    (SERH),
      .POST_EQ_A     (POSTA),
      .POST_EQ_B     (POSTB),
      .POS_W         (PW),
      .ROW_W         (RW)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_end  (line_end),
      .clk_pos   (clk_pos),
      .hsync_in  (hsync_in),
      .line_kind (line_kind),
      .row       (row),
      .field_odd (field_odd),
      .sync_out  (sync_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // expected outputs from the requirement arithmetic
   task automatic model(input int f, input int l, input int p, input int hs,
                        output int kind, output int rw, output int sy,
                        output int ser);
      int top, v, h, off, pre;
      top  = f ? TB : TA;
      rw   = 0;
      sy   = hs;
      ser  = 0;
      if (l < top) kind = 0;
      else if (l < top + ACT) begin
         kind = 1;
         rw   = l - top;
      end else if (l < top + ACT + BOT) kind = 0;
      else begin
         kind = 2;
         v    = l - (top + ACT + BOT);
         h    = 2 * v + ((p >= HALF) ? 1 : 0);
         off  = p % HALF;
         pre  = f ? PREB : PREA;
         ser  = (h >= pre && h < pre + SERH) ? 1 : 0;
         sy   = (off < (ser ? SERS : EQS)) ? 1 : 0;
      end
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired before end of run: got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int ek, er, es, eser, hs;
      rst_n    = 1'b0;
      line_end = 1'b0;
      clk_pos  = '0;
      hsync_in = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset line_kind", int'(line_kind), 0);
      chk("R1 reset row", int'(row), 0);
      chk("R1 reset field_odd", int'(field_odd), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;

      // no line_end: state must hold while position and hsync wander
      for (int k = 0; k < 12; k++) begin
         @(posedge clk);
         #1;
         clk_pos  = PW'((k * 7) % LC);
         hsync_in = k[0];
         line_end = 1'b0;
         @(negedge clk);
         chk("R12 hold line_kind without line_end", int'(line_kind), 0);
         chk("R12 hold field_odd without line_end", int'(field_odd), 0);
         chk("R1 row after reset", int'(row), 0);
         chk("R11 pass-through in overscan", int'(sync_out), k % 2);
      end

      // three frames, every clock of every line
      for (int fr = 0; fr < 3; fr++) begin
         for (int f = 0; f < 2; f++) begin
            for (int l = 0; l < (f ? FB : FA); l++) begin
               for (int p = 0; p < LC; p++) begin
                  @(posedge clk);
                  #1;
                  hs       = (((p * 5) + l + fr) % 3 == 0) ? 1 : 0;
                  clk_pos  = PW'(p);
                  hsync_in = hs[0];
                  line_end = (p == LC - 1);
                  model(f, l, p, hs, ek, er, es, eser);
                  @(negedge clk);
                  chk(f ? "R3 short-field line_kind" : "R2 long-field line_kind",
                      int'(line_kind), ek);
                  chk("R4 row", int'(row), er);
                  chk("R5 field_odd alternation", int'(field_odd), f);
                  if (ek == 2) begin
                     chk($sformatf("R6/%s/%s vertical sync f%0d l%0d p%0d",
                                   eser ? "R8" : "R7", f ? "R10" : "R9", f, l, p),
                         int'(sync_out), es);
                  end else begin
                     chk("R11 pass-through", int'(sync_out), es);
                  end
               end
            end
         end
      end

      @(posedge clk);
      #1 line_end = 1'b0;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule